// File: doc/BRIEF.md
# Time-Slotted Shared CORDIC Rotator

This block is one fully pipelined vector rotator that sixteen requesters share. A rotating slot counter hands the block to exactly one requester per clock, and the hub presents that requester's signals on a single shared request port. While it owns the slot, the requester may inject a 16-bit signed X/Y pair and a 16-bit angle. It may also collect the result that is waiting in its private result register.

Each operation enters a quadrant-folding stage. It then passes through sixteen micro-rotation stages, one per clock, carrying the tag of the requester that issued it. At the end it lands in that requester's own result register. The block applies no gain correction, so results carry the raw CORDIC gain of about 1.6468 and are two bits wider than the operands. Scaling is left to the requester. The latency is fixed and a new operation is accepted on every clock, so each requester sees deterministic timing relative to its own slot and never waits for another requester.

Top module: `scordic_hub`

## Requirements
- R1: After reset the slot index reads 0. It advances by one each clock and wraps from 15 to 0.
- R2: Reset clears the valid flag of every result register, so no requester sees a result before it issues one.
- R3: An operation issued in clock cycle t becomes visible in the issuer's result register from cycle t+18. It is therefore first collectable on the issuer's slot at cycle t+32. A new operation can be issued in every cycle.
- R4: The result equals the operand vector rotated by the angle and multiplied by the uncorrected gain 1.64676, so that x_out = K(x·cosθ − y·sinθ) and y_out = K(x·sinθ + y·cosθ). Each output is an 18-bit signed value within 48 LSB of this.
- R5: The angle is an unsigned 16-bit fraction of a full turn (0x4000 = 90°, 0x8000 = 180°, 0xC000 = 270°). Angles in all four quadrants, including values just below 0x8000, meet R4.
- R6: A completed result sets only its issuer's valid flag. The read outputs always show the register of the current slot owner, so no requester observes or alters another's result.
- R7: Asserting collect on a slot while a result is valid clears that requester's valid flag from the next cycle on.
- R8: If a requester issues again before collecting, the newer result replaces the older one when it completes.
- R9: Operand values presented while issue is low start nothing and change no result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_o | output | 4 | Index of the requester owning the current cycle |
| issue_i | input | 1 | Slot owner starts an operation this cycle |
| x_i | input | 16 | Signed X operand |
| y_i | input | 16 | Signed Y operand |
| ang_i | input | 16 | Rotation angle, unsigned fraction of a turn |
| collect_i | input | 1 | Slot owner consumes its result this cycle |
| rdy_o | output | 1 | Slot owner's result register holds an uncollected result |
| rx_o | output | 18 | Slot owner's X result, signed, raw gain |
| ry_o | output | 18 | Slot owner's Y result, signed, raw gain |

## Verification
The bench builds the block with its default values: 16 requesters, 16-bit operands, two guard bits and sixteen micro-rotation stages. With these values the 18-cycle latency is longer than one rotation, so up to two operations from the same requester are in flight at once. This exposes the overwrite case and the rule that a result is collected two rotations after issue. A full rotation of back-to-back issues fills every stage with a different tag. Angles on and next to the quadrant boundaries, together with operands at full scale, exercise the fold stage and the width of the guard bits.

// File: rtl/scordic_pkg.sv
// Shared constants for the slotted CORDIC rotator.
// Assumes a 16-bit angle where 2^16 counts one full turn.
package scordic_pkg;

    localparam int ANG_W = 16;

    // Arctangent of 2^-i expressed in turn units (65536 per turn), rounded.
    function automatic logic [ANG_W-1:0] atan_step(input int i);
        case (i)
            0:       return 16'd8192;
            1:       return 16'd4836;
            2:       return 16'd2555;
            3:       return 16'd1297;
            4:       return 16'd651;
            5:       return 16'd326;
            6:       return 16'd163;
            7:       return 16'd81;
            8:       return 16'd41;
            9:       return 16'd20;
            10:      return 16'd10;
            11:      return 16'd5;
            12:      return 16'd3;
            13:      return 16'd1;
            14:      return 16'd1;
            default: return 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/sc_slot_ring.sv
// Rotating slot counter: grants one requester per clock in strict order.
// Assumes a synchronous active-low reset that returns the grant to requester 0.
module sc_slot_ring #(
    parameter int N_REQ = 16,
    localparam int SW = $clog2(N_REQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] slot
);
    // Advance the grant and wrap after the last requester.
    always_ff @(posedge clk) begin
        if (!rst_n)                              slot <= '0;
        else if (slot == SW'(N_REQ - 1))         slot <= '0;
        else                                     slot <= slot + 1'b1;
    end
endmodule

// File: rtl/sc_prerot.sv
// Quadrant fold: turns the operand by +/-90 degrees when the angle lies in
// the back half-turn, so the residual angle stays inside the range the
// micro-rotations can converge over. Registered, carries valid and tag.
module sc_prerot #(
    parameter int DW = 16,
    parameter int IW = 18,
    parameter int TW = 4,
    localparam int AW = scordic_pkg::ANG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_v,
    input  logic [TW-1:0]        in_tag,
    input  logic signed [DW-1:0] in_x,
    input  logic signed [DW-1:0] in_y,
    input  logic [AW-1:0]        in_a,
    output logic                 out_v,
    output logic [TW-1:0]        out_tag,
    output logic signed [IW-1:0] out_x,
    output logic signed [IW-1:0] out_y,
    output logic [AW-1:0]        out_z
);
    localparam logic [AW-1:0] QTR = AW'(1) << (AW - 2);

    logic signed [IW-1:0] wx, wy, fx, fy;
    logic [AW-1:0]        fz;

    assign wx = IW'(in_x);
    assign wy = IW'(in_y);

    // Choose the fold from the two top angle bits.
    always_comb begin
        fx = wx;
        fy = wy;
        fz = in_a;
        case (in_a[AW-1:AW-2])
            2'b01: begin fx = -wy; fy = wx;  fz = in_a - QTR; end
            2'b10: begin fx = wy;  fy = -wx; fz = in_a + QTR; end
            default: ;
        endcase
    end

    // Valid bit under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_v <= 1'b0;
        else        out_v <= in_v;
    end

    // Payload register.
    always_ff @(posedge clk) begin
        out_tag <= in_tag;
        out_x   <= fx;
        out_y   <= fy;
        out_z   <= fz;
    end
endmodule

// File: rtl/sc_micro_rot.sv
// One CORDIC micro-rotation by +/-atan(2^-SHIFT), direction from the sign of
// the residual angle. Registered; carries valid and requester tag.
module sc_micro_rot #(
    parameter int IW    = 18,
    parameter int TW    = 4,
    parameter int SHIFT = 0,
    localparam int AW   = scordic_pkg::ANG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_v,
    input  logic [TW-1:0]        in_tag,
    input  logic signed [IW-1:0] in_x,
    input  logic signed [IW-1:0] in_y,
    input  logic [AW-1:0]        in_z,
    output logic                 out_v,
    output logic [TW-1:0]        out_tag,
    output logic signed [IW-1:0] out_x,
    output logic signed [IW-1:0] out_y,
    output logic [AW-1:0]        out_z
);
    localparam logic [AW-1:0] STEP = scordic_pkg::atan_step(SHIFT);

    logic signed [IW-1:0] sx, sy;
    assign sx = in_x >>> SHIFT;
    assign sy = in_y >>> SHIFT;

    // Valid bit under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_v <= 1'b0;
        else        out_v <= in_v;
    end

    // Rotate towards zero residual angle.
    always_ff @(posedge clk) begin
        out_tag <= in_tag;
        if (in_z[AW-1]) begin
            out_x <= in_x + sy;
            out_y <= in_y - sx;
            out_z <= in_z + STEP;
        end else begin
            out_x <= in_x - sy;
            out_y <= in_y + sx;
            out_z <= in_z - STEP;
        end
    end
endmodule

// File: rtl/sc_result_bank.sv
// Private result registers, one per requester, each with a valid flag.
// Writes come from the pipeline end by tag; reads and clears follow the slot.
// Assumes the pipeline never writes the register of the current slot owner.
module sc_result_bank #(
    parameter int N_REQ = 16,
    parameter int IW    = 18,
    localparam int SW   = $clog2(N_REQ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SW-1:0]        wtag,
    input  logic signed [IW-1:0] wx,
    input  logic signed [IW-1:0] wy,
    input  logic [SW-1:0]        slot,
    input  logic                 collect,
    output logic [N_REQ-1:0]     vld,
    output logic                 rd_v,
    output logic signed [IW-1:0] rd_x,
    output logic signed [IW-1:0] rd_y
);
    logic signed [IW-1:0] rx [N_REQ];
    logic signed [IW-1:0] ry [N_REQ];

    // Valid flags: clear on collect, set on write (write wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (collect) vld[slot] <= 1'b0;
            if (we)      vld[wtag] <= 1'b1;
        end
    end

    // Result data storage.
    always_ff @(posedge clk) begin
        if (we) begin
            rx[wtag] <= wx;
            ry[wtag] <= wy;
        end
    end

    assign rd_v = vld[slot];
    assign rd_x = rx[slot];
    assign rd_y = ry[slot];
endmodule

// File: rtl/scordic_hub.sv
// Shared, time-slotted CORDIC rotator. One requester owns each clock; the
// owner may issue an operation and/or collect its own result. Outputs carry
// the uncorrected CORDIC gain. Assumes the hub muxes the owner onto the ports.
module scordic_hub #(
    parameter int N_REQ  = 16,
    parameter int DATA_W = 16,
    parameter int GUARD  = 2,
    parameter int STAGES = 16,
    localparam int SW    = $clog2(N_REQ),
    localparam int IW    = DATA_W + GUARD,
    localparam int AW    = scordic_pkg::ANG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SW-1:0]     slot_o,
    input  logic              issue_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic [AW-1:0]     ang_i,
    input  logic              collect_i,
    output logic              rdy_o,
    output logic [IW-1:0]     rx_o,
    output logic [IW-1:0]     ry_o
);
    logic                 sv   [STAGES+1];
    logic [SW-1:0]        stag [STAGES+1];
    logic signed [IW-1:0] sx   [STAGES+1];
    logic signed [IW-1:0] sy   [STAGES+1];
    logic [AW-1:0]        sz   [STAGES+1];

    logic [N_REQ-1:0]     res_vld;
    logic                 bank_we;
    logic [SW-1:0]        bank_tag;
    logic signed [IW-1:0] bank_rx, bank_ry;

    sc_slot_ring #(.N_REQ(N_REQ)) u_ring (
        .clk(clk), .rst_n(rst_n), .slot(slot_o)
    );

    sc_prerot #(.DW(DATA_W), .IW(IW), .TW(SW)) u_fold (
        .clk(clk), .rst_n(rst_n),
        .in_v(issue_i), .in_tag(slot_o),
        .in_x(x_i), .in_y(y_i), .in_a(ang_i),
        .out_v(sv[0]), .out_tag(stag[0]),
        .out_x(sx[0]), .out_y(sy[0]), .out_z(sz[0])
    );

    for (genvar k = 0; k < STAGES; k++) begin : g_iter
        sc_micro_rot #(.IW(IW), .TW(SW), .SHIFT(k)) u_rot (
            .clk(clk), .rst_n(rst_n),
            .in_v(sv[k]), .in_tag(stag[k]),
            .in_x(sx[k]), .in_y(sy[k]), .in_z(sz[k]),
            .out_v(sv[k+1]), .out_tag(stag[k+1]),
            .out_x(sx[k+1]), .out_y(sy[k+1]), .out_z(sz[k+1])
        );
    end

    assign bank_we  = sv[STAGES];
    assign bank_tag = stag[STAGES];

    sc_result_bank #(.N_REQ(N_REQ), .IW(IW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .we(bank_we), .wtag(bank_tag),
        .wx(sx[STAGES]), .wy(sy[STAGES]),
        .slot(slot_o), .collect(collect_i),
        .vld(res_vld), .rd_v(rdy_o), .rd_x(bank_rx), .rd_y(bank_ry)
    );

    assign rx_o = bank_rx;
    assign ry_o = bank_ry;
endmodule

// File: rtl/scordic_hub_chk.sv
// Property checker for the slotted rotator, attached by bind.
module scordic_hub_chk #(
    parameter int N_REQ = 16,
    parameter int SW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SW-1:0]    slot,
    input logic             collect,
    input logic [N_REQ-1:0] vld,
    input logic             wr_en,
    input logic [SW-1:0]    wr_tag
);
    p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> slot == SW'($past(slot) + 1'b1));

    p_reset_clear_r2: assert property (@(posedge clk)
        !rst_n |=> vld == '0);

    p_tag_not_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_tag != slot);

    p_single_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $countones(vld & ~$past(vld)) <= 1);

    p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        collect |=> !vld[$past(slot)]);
endmodule

bind scordic_hub scordic_hub_chk #(.N_REQ(N_REQ), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .slot(slot_o), .collect(collect_i),
    .vld(res_vld), .wr_en(bank_we), .wr_tag(bank_tag)
);

// File: tb/tb_scordic_hub.sv
module tb_scordic_hub;
    localparam int    LAT = 18;
    localparam real   KG  = 1.6467602581;
    localparam real   TOL = 48.0;
    localparam real   PI2 = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  slot_o;
    logic        issue_i = 1'b0;
    logic [15:0] x_i = '0, y_i = '0, ang_i = '0;
    logic        collect_i = 1'b0;
    logic        rdy_o;
    logic [17:0] rx_o, ry_o;

    int checks = 0, failures = 0;
    int mcyc = 0, mslot = 0;
    bit done = 0;

    // reference model state
    int    q_due[$];
    int    q_tag[$];
    real   q_ex[$];
    real   q_ey[$];
    string q_lb[$];
    bit    m_have[16];
    real   m_ex[16];
    real   m_ey[16];
    string m_lb[16];

    always #2 clk = ~clk;   // 250 MHz

    scordic_hub dut (
        .clk(clk), .rst_n(rst_n), .slot_o(slot_o), .issue_i(issue_i),
        .x_i(x_i), .y_i(y_i), .ang_i(ang_i), .collect_i(collect_i),
        .rdy_o(rdy_o), .rx_o(rx_o), .ry_o(ry_o)
    );

    function automatic real absr(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    // One model cycle: settle completions, compare, drive, advance.
    task automatic cyc(input bit iss, input logic [15:0] x, input logic [15:0] y,
                       input logic [15:0] a, input bit col, input string lb);
        real th, gx, gy;
        while (q_due.size() > 0 && q_due[0] == mcyc) begin
            m_have[q_tag[0]] = 1'b1;
            m_ex[q_tag[0]] = q_ex[0];
            m_ey[q_tag[0]] = q_ey[0];
            m_lb[q_tag[0]] = q_lb[0];
            void'(q_due.pop_front()); void'(q_tag.pop_front());
            void'(q_ex.pop_front());  void'(q_ey.pop_front());
            void'(q_lb.pop_front());
        end
        checks++;
        if (slot_o != 4'(mslot)) begin
            failures++;
            $display("FAIL R1 slot actual=%0d expected=%0d", slot_o, mslot);
        end
        checks++;
        if (rdy_o != m_have[mslot]) begin
            failures++;
            $display("FAIL R3/R6/R7 valid slot %0d cycle %0d actual=%0b expected=%0b",
                     mslot, mcyc, rdy_o, m_have[mslot]);
        end
        if (rdy_o && m_have[mslot]) begin
            gx = $itor($signed(rx_o));
            gy = $itor($signed(ry_o));
            checks++;
            if (absr(gx - m_ex[mslot]) > TOL || absr(gy - m_ey[mslot]) > TOL) begin
                failures++;
                $display("FAIL %s data slot %0d actual=(%0d,%0d) expected=(%0.1f,%0.1f)",
                         m_lb[mslot], mslot, $signed(rx_o), $signed(ry_o),
                         m_ex[mslot], m_ey[mslot]);
            end
        end
        issue_i = iss; x_i = x; y_i = y; ang_i = a; collect_i = col;
        if (col) m_have[mslot] = 1'b0;
        if (iss) begin
            th = PI2 * $itor(a) / 65536.0;
            q_due.push_back(mcyc + LAT);
            q_tag.push_back(mslot);
            q_ex.push_back(KG * ($itor($signed(x)) * $cos(th) - $itor($signed(y)) * $sin(th)));
            q_ey.push_back(KG * ($itor($signed(x)) * $sin(th) + $itor($signed(y)) * $cos(th)));
            q_lb.push_back(lb);
        end
        mcyc++;
        mslot = (mslot + 1) % 16;
        @(negedge clk);
    endtask

    // R9: idle cycles carry junk operands with issue low.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            cyc(1'b0, 16'h5A5A ^ 16'(mcyc), 16'hA5A5, 16'(mcyc * 977), 1'b0, "R9");
    endtask

    task automatic to_slot(input int s);
        while (mslot != s) idle(1);
    endtask

    task automatic op(input int s, input logic [15:0] x, input logic [15:0] y,
                      input logic [15:0] a, input string lb);
        to_slot(s);
        cyc(1'b1, x, y, a, 1'b0, lb);
    endtask

    task automatic take(input int s);
        to_slot(s);
        cyc(1'b0, '0, '0, '0, 1'b1, "R7");
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: nothing valid after reset
        idle(20);
        // R3/R4: single operation, collected two rotations later
        op(3, 16'd10000, 16'd0, 16'h0000, "R4");
        idle(40);
        take(3);
        idle(20);
        // R5: quadrants and boundaries
        op(0, 16'd12000, 16'd5000, 16'h4000, "R5");
        op(1, 16'd12000, 16'd5000, 16'h8000, "R5");
        op(2, 16'd12000, 16'd5000, 16'hC000, "R5");
        op(3, 16'd12000, 16'd5000, 16'h2000, "R5");
        op(4, 16'd12000, 16'd5000, 16'h7FF0, "R5");
        op(5, 16'h8000, 16'h8000, 16'h6000, "R5");
        op(6, 16'h7FFF, 16'h7FFF, 16'hBFFF, "R5");
        idle(40);
        for (int s = 0; s < 7; s++) take(s);
        // R3/R6: a full rotation of back-to-back issues
        to_slot(0);
        for (int k = 0; k < 16; k++)
            cyc(1'b1, 16'(1000 * k - 8000), 16'(3000 - 500 * k), 16'(k * 4099), 1'b0, "R6");
        idle(40);
        for (int s = 0; s < 16; s++) take(s);
        idle(20);
        // R8: second issue before the first is collected
        op(7, 16'd9000, 16'd0, 16'h1000, "R8");
        op(7, 16'd9000, 16'd0, 16'h3000, "R8");
        idle(60);
        take(7);
        idle(40);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R3 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule